// File: doc/BRIEF.md
# Reuse-distance replacement unit

This block picks eviction victims for a small fully associative cache. It sorts blocks into two classes. The low-reuse-distance class (LIR) is always resident. The high-reuse-distance class (HIR) may be resident, or it may be non-resident, which means only its tag is still remembered. Two structures track this. A bounded recency stack orders every LIR block together with the HIR tags seen recently. A FIFO holds the resident HIR blocks in the order they became resident. The unit stores no data and applies no write policy.

A client presents one tag on the request port while `req_ready` is high. The unit then updates the stack and the FIFO over a few cycles. It finishes by pulsing `done` for one cycle. At that point `hit`, `class_lir` and `victim_valid`/`victim_tag` describe the access. These results are held until the next request is accepted. A tag that has left the recency stack must show reuse again before it can join the LIR class.

Top module: `rdr_repl_unit`

## Requirements
- R1: While reset is asserted, and just after it is released, `req_ready` is 1 and `done`, `hit`, `victim_valid` and `class_lir` are 0.
- R2: While fewer than LIR_SLOTS blocks are LIR, a missing tag becomes LIR (`class_lir`=1, where 1 means LIR and 0 means HIR). No victim is named.
- R3: Once the LIR class is full, a tag absent from both structures misses. It becomes a resident HIR block (`class_lir`=0) and enters the FIFO at its tail.
- R4: A miss names a victim (`victim_valid`=1) only when LIR_SLOTS+HIR_SLOTS blocks are already resident. The victim is the head of the FIFO, which is the oldest resident HIR block. If that block's tag is still on the stack, it stays there as non-resident.
- R5: A hit on an LIR block reports `hit`=1 and `class_lir`=1. The unit then pops HIR entries off the stack bottom until an LIR entry sits there.
- R6: A hit on a resident HIR block whose tag is on the stack promotes it to LIR and takes it out of the FIFO. The LIR block at the stack bottom is then demoted to resident HIR and appended to the FIFO.
- R7: A hit on a resident HIR block whose tag is not on the stack reports `hit`=1 and `class_lir`=0. The block moves to the FIFO tail.
- R8: A non-resident tag still on the stack misses (`hit`=0), evicts the FIFO head and becomes LIR (`class_lir`=1). The bottom LIR block is demoted as in R6.
- R9: If the stack holds S_DEPTH entries and a new tag is pushed, the deepest non-resident entry is dropped. A dropped tag that is referenced again is handled as a brand-new tag.
- R10: `done` rises 3 clock edges after the edge that accepts the request. A demotion adds 1 edge, and each entry popped at the stack bottom adds 1 more.
- R11: `req_ready` is low from acceptance until `done` has been seen. `done` lasts one cycle. The result outputs hold their values while the unit sits idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request strobe |
| req_tag | input | TAG_W | Tag of the accessed block |
| req_ready | output | 1 | Unit is idle and takes a request |
| done | output | 1 | One-cycle pulse: results valid |
| hit | output | 1 | 1 when the accessed block was resident |
| victim_valid | output | 1 | 1 when this access evicted a block |
| victim_tag | output | TAG_W | Tag of the evicted block |
| class_lir | output | 1 | New class of the accessed block: 1 LIR, 0 HIR |

## Verification
The delay between acceptance and `done` depends on the access. The base is three edges. A demotion adds one edge, and each pruned stack entry adds one more. The bench drives each request for one edge and counts falling edges until `done` appears. It compares that count with the figure it derived by hand for the case, and only then reads `hit`, `class_lir` and the victim outputs. Those outputs are sampled mid-cycle, on the one cycle `done` is high. They are sampled again after several idle cycles to confirm they have held.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

  typedef enum logic [1:0] {
    S_NOP,
    S_MARK_NR,
    S_PUSH_TOP,
    S_POP_BOT
  } s_cmd_e;

  typedef enum logic [1:0] {
    Q_NOP,
    Q_POP_HEAD,
    Q_REMOVE,
    Q_PUSH_TAIL
  } q_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_PROMOTE,
    ST_DEMOTE,
    ST_PRUNE,
    ST_DONE
  } st_e;

  typedef enum logic [2:0] {
    K_LIR_HIT,
    K_HIR_IN_S,
    K_HIR_OUT_S,
    K_NR_IN_S,
    K_NEW_HIR,
    K_WARM
  } kind_e;

endpackage

// File: rtl/rdr_recency_stack.sv
module rdr_recency_stack
  import rdr_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int DEPTH = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  s_cmd_e           cmd,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             cmd_lir,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_found,
  output logic             look_lir,
  output logic             look_res,
  output logic             bot_valid,
  output logic [TAG_W-1:0] bot_tag,
  output logic             bot_lir,
  output logic [CNT_W-1:0] lir_cnt
);

  // entry 0 is the most recent; entries below cnt_q are live
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];
  logic [DEPTH-1:0] lir_q, lir_d, res_q, res_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic             cm_found;
  logic [CNT_W-1:0] cm_idx;
  logic             nr_found;
  logic [CNT_W-1:0] nr_idx, hr_idx, rm_idx;
  logic             full;

  always_comb begin
    look_found = 1'b0;
    look_lir   = 1'b0;
    look_res   = 1'b0;
    cm_found   = 1'b0;
    cm_idx     = '0;
    nr_found   = 1'b0;
    nr_idx     = '0;
    hr_idx     = '0;
    bot_valid  = 1'b0;
    bot_tag    = '0;
    bot_lir    = 1'b0;
    lir_cnt    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < cnt_q) begin
        if (tag_q[i] == look_tag && !look_found) begin
          look_found = 1'b1;
          look_lir   = lir_q[i];
          look_res   = res_q[i];
        end
        if (tag_q[i] == cmd_tag && !cm_found) begin
          cm_found = 1'b1;
          cm_idx   = CNT_W'(i);
        end
        if (!lir_q[i] && !res_q[i]) begin
          nr_found = 1'b1;
          nr_idx   = CNT_W'(i);
        end
        if (!lir_q[i]) begin
          hr_idx = CNT_W'(i);
        end
        if (lir_q[i]) begin
          lir_cnt = lir_cnt + CNT_W'(1);
        end
        if (CNT_W'(i) == cnt_q - CNT_W'(1)) begin
          bot_valid = 1'b1;
          bot_tag   = tag_q[i];
          bot_lir   = lir_q[i];
        end
      end
    end
  end

  assign full = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    if (cm_found) begin
      rm_idx = cm_idx;
    end else if (full) begin
      rm_idx = nr_found ? nr_idx : hr_idx;
    end else begin
      rm_idx = cnt_q;
    end
  end

  always_comb begin
    tag_d = tag_q;
    lir_d = lir_q;
    res_d = res_q;
    cnt_d = cnt_q;
    unique case (cmd)
      S_PUSH_TOP: begin
        tag_d[0] = cmd_tag;
        lir_d[0] = cmd_lir;
        res_d[0] = 1'b1;
        for (int i = 1; i < DEPTH; i++) begin
          if (CNT_W'(i) <= rm_idx) begin
            tag_d[i] = tag_q[i-1];
            lir_d[i] = lir_q[i-1];
            res_d[i] = res_q[i-1];
          end
        end
        if (!cm_found && !full) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      S_MARK_NR: begin
        for (int i = 0; i < DEPTH; i++) begin
          if (cm_found && CNT_W'(i) == cm_idx) begin
            res_d[i] = 1'b0;
          end
        end
      end
      S_POP_BOT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lir_q <= '0;
      res_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lir_q <= lir_d;
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd == S_PUSH_TOP) begin
      tag_q <= tag_d;
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == S_POP_BOT) |-> (cnt_q != '0)); // R5

endmodule

// File: rtl/rdr_resident_fifo.sv
module rdr_resident_fifo
  import rdr_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  q_cmd_e           cmd,
  input  logic [TAG_W-1:0] cmd_tag,
  output logic             found,
  output logic [TAG_W-1:0] head_tag,
  output logic [CNT_W-1:0] cnt
);

  // entry 0 is the oldest resident HIR block
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];
  logic [TAG_W-1:0] mid_tag [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, mid_cnt;
  logic [CNT_W-1:0] idx, rm_idx;
  logic             rm_en;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < cnt_q && tag_q[i] == cmd_tag && !found) begin
        found = 1'b1;
        idx   = CNT_W'(i);
      end
    end
  end

  assign head_tag = tag_q[0];
  assign cnt      = cnt_q;

  always_comb begin
    rm_en  = 1'b0;
    rm_idx = '0;
    unique case (cmd)
      Q_POP_HEAD: begin
        rm_en  = (cnt_q != '0);
        rm_idx = '0;
      end
      Q_REMOVE, Q_PUSH_TAIL: begin
        rm_en  = found;
        rm_idx = idx;
      end
      default: begin
      end
    endcase
  end

  always_comb begin
    mid_tag = tag_q;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (rm_en && CNT_W'(i) >= rm_idx) begin
        mid_tag[i] = tag_q[i+1];
      end
    end
    mid_cnt = rm_en ? (cnt_q - CNT_W'(1)) : cnt_q;
    tag_d   = mid_tag;
    cnt_d   = mid_cnt;
    if (cmd == Q_PUSH_TAIL && mid_cnt < CNT_W'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == mid_cnt) begin
          tag_d[i] = cmd_tag;
        end
      end
      cnt_d = mid_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd != Q_NOP) begin
      tag_q <= tag_d;
    end
  end

  AST_NO_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == Q_PUSH_TAIL && !found) |-> (cnt_q < CNT_W'(DEPTH))); // R4

endmodule

// File: rtl/rdr_ctrl.sv
module rdr_ctrl
  import rdr_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int LIR_SLOTS = 4,
  parameter int HIR_SLOTS = 2,
  parameter int S_DEPTH   = 12,
  localparam int SC_W = $clog2(S_DEPTH + 1),
  localparam int QC_W = $clog2(HIR_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  output logic             ready,
  output logic             done,
  output logic             hit,
  output logic             victim_valid,
  output logic [TAG_W-1:0] victim_tag,
  output logic             class_lir,
  output s_cmd_e           s_cmd,
  output logic [TAG_W-1:0] s_cmd_tag,
  output logic             s_cmd_lir,
  output logic [TAG_W-1:0] s_look_tag,
  input  logic             s_found,
  input  logic             s_lir,
  input  logic             s_res,
  input  logic             s_bot_valid,
  input  logic [TAG_W-1:0] s_bot_tag,
  input  logic             s_bot_lir,
  input  logic [SC_W-1:0]  s_lir_cnt,
  output q_cmd_e           q_cmd,
  output logic [TAG_W-1:0] q_cmd_tag,
  input  logic             q_found,
  input  logic [TAG_W-1:0] q_head_tag,
  input  logic [QC_W-1:0]  q_cnt
);

  st_e              st_q, st_d;
  kind_e            kind_q, kind_c;
  logic [TAG_W-1:0] tag_q;
  logic             hit_q, lir_q, vv_q;
  logic [TAG_W-1:0] vt_q;
  logic             resident, warm, full, evict_c, new_lir_c, promo;

  assign resident  = (s_found && (s_lir || s_res)) || q_found;
  assign warm      = int'(s_lir_cnt) < LIR_SLOTS;
  assign full      = (int'(s_lir_cnt) + int'(q_cnt)) >= (LIR_SLOTS + HIR_SLOTS);
  assign evict_c   = !resident && !warm && full;
  assign promo     = (kind_q == K_HIR_IN_S) || (kind_q == K_NR_IN_S);

  always_comb begin
    if (s_found && s_lir) begin
      kind_c = K_LIR_HIT;
    end else if (resident && s_found) begin
      kind_c = K_HIR_IN_S;
    end else if (resident) begin
      kind_c = K_HIR_OUT_S;
    end else if (warm) begin
      kind_c = K_WARM;
    end else if (s_found) begin
      kind_c = K_NR_IN_S;
    end else begin
      kind_c = K_NEW_HIR;
    end
  end

  assign new_lir_c = (kind_c == K_LIR_HIT) || (kind_c == K_HIR_IN_S) ||
                     (kind_c == K_NR_IN_S) || (kind_c == K_WARM);

  // next state and command decode
  always_comb begin
    st_d       = st_q;
    s_cmd      = S_NOP;
    s_cmd_tag  = tag_q;
    s_cmd_lir  = lir_q;
    q_cmd      = Q_NOP;
    q_cmd_tag  = tag_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) st_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (evict_c) begin
          if (q_cnt != '0) begin
            q_cmd     = Q_POP_HEAD;
            s_cmd     = S_MARK_NR;
            s_cmd_tag = q_head_tag;
          end else if (s_bot_valid) begin
            s_cmd = S_POP_BOT;
          end
        end
        st_d = ST_PROMOTE;
      end
      ST_PROMOTE: begin
        s_cmd = S_PUSH_TOP;
        unique case (kind_q)
          K_HIR_IN_S:             q_cmd = Q_REMOVE;
          K_HIR_OUT_S, K_NEW_HIR: q_cmd = Q_PUSH_TAIL;
          default:                q_cmd = Q_NOP;
        endcase
        st_d = promo ? ST_DEMOTE : ST_PRUNE;
      end
      ST_DEMOTE: begin
        if (s_bot_valid && s_bot_lir) begin
          s_cmd     = S_POP_BOT;
          q_cmd     = Q_PUSH_TAIL;
          q_cmd_tag = s_bot_tag;
        end
        st_d = ST_PRUNE;
      end
      ST_PRUNE: begin
        if (s_bot_valid && !s_bot_lir) begin
          s_cmd = S_POP_BOT;
        end else begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_WARM;
      hit_q  <= 1'b0;
      lir_q  <= 1'b0;
      vv_q   <= 1'b0;
      vt_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_LOOKUP) begin
        kind_q <= kind_c;
        hit_q  <= resident;
        lir_q  <= new_lir_c;
        vv_q   <= evict_c;
        if (evict_c) begin
          vt_q <= (q_cnt != '0) ? q_head_tag : s_bot_tag;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_IDLE && req_valid) begin
      tag_q <= req_tag;
    end
  end

  assign s_look_tag   = tag_q;
  assign ready        = (st_q == ST_IDLE);
  assign done         = (st_q == ST_DONE);
  assign hit          = hit_q;
  assign class_lir    = lir_q;
  assign victim_valid = vv_q;
  assign victim_tag   = vt_q;

  AST_LIR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (int'(s_lir_cnt) <= LIR_SLOTS)); // R2
  AST_BOTTOM_LIR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && s_bot_valid) |-> s_bot_lir); // R5
  AST_VICTIM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && victim_valid) |-> !hit); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> !ready); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !req_valid) |=> $stable({hit, class_lir, victim_valid, victim_tag})); // R11

endmodule

// File: rtl/rdr_repl_unit.sv
module rdr_repl_unit
  import rdr_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int LIR_SLOTS = 4,
  parameter int HIR_SLOTS = 2,
  parameter int S_DEPTH   = 12,
  localparam int SC_W = $clog2(S_DEPTH + 1),
  localparam int QC_W = $clog2(HIR_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  output logic             done,
  output logic             hit,
  output logic             victim_valid,
  output logic [TAG_W-1:0] victim_tag,
  output logic             class_lir
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  s_cmd_e           s_cmd;
  logic [TAG_W-1:0] s_cmd_tag, s_look_tag, s_bot_tag;
  logic             s_cmd_lir, s_found, s_lir, s_res, s_bot_valid, s_bot_lir;
  logic [SC_W-1:0]  s_lir_cnt;
  q_cmd_e           q_cmd;
  logic [TAG_W-1:0] q_cmd_tag, q_head_tag;
  logic             q_found;
  logic [QC_W-1:0]  q_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  rdr_ctrl #(
    .TAG_W(TAG_W), .LIR_SLOTS(LIR_SLOTS), .HIR_SLOTS(HIR_SLOTS), .S_DEPTH(S_DEPTH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_int),
    .req_valid(req_valid), .req_tag(req_tag), .ready(req_ready), .done(done),
    .hit(hit), .victim_valid(victim_valid), .victim_tag(victim_tag), .class_lir(class_lir),
    .s_cmd(s_cmd), .s_cmd_tag(s_cmd_tag), .s_cmd_lir(s_cmd_lir), .s_look_tag(s_look_tag),
    .s_found(s_found), .s_lir(s_lir), .s_res(s_res),
    .s_bot_valid(s_bot_valid), .s_bot_tag(s_bot_tag), .s_bot_lir(s_bot_lir),
    .s_lir_cnt(s_lir_cnt),
    .q_cmd(q_cmd), .q_cmd_tag(q_cmd_tag), .q_found(q_found),
    .q_head_tag(q_head_tag), .q_cnt(q_cnt)
  );

  rdr_recency_stack #(.TAG_W(TAG_W), .DEPTH(S_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n_int),
    .cmd(s_cmd), .cmd_tag(s_cmd_tag), .cmd_lir(s_cmd_lir), .look_tag(s_look_tag),
    .look_found(s_found), .look_lir(s_lir), .look_res(s_res),
    .bot_valid(s_bot_valid), .bot_tag(s_bot_tag), .bot_lir(s_bot_lir),
    .lir_cnt(s_lir_cnt)
  );

  rdr_resident_fifo #(.TAG_W(TAG_W), .DEPTH(HIR_SLOTS)) u_fifo (
    .clk(clk), .rst_n(rst_n_int),
    .cmd(q_cmd), .cmd_tag(q_cmd_tag),
    .found(q_found), .head_tag(q_head_tag), .cnt(q_cnt)
  );

endmodule

// File: tb/rdr_repl_unit_tb.sv
`timescale 1ns/1ps
module rdr_repl_unit_tb;

  localparam int TW = 8;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [TW-1:0] req_tag;
  logic          req_ready, done, hit, victim_valid, class_lir;
  logic [TW-1:0] victim_tag;

  int total = 0;
  int bad   = 0;

  rdr_repl_unit #(.TAG_W(TW), .LIR_SLOTS(2), .HIR_SLOTS(1), .S_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .req_ready(req_ready), .done(done), .hit(hit), .victim_valid(victim_valid),
    .victim_tag(victim_tag), .class_lir(class_lir)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // one access: drive for one edge, count edges to done, check results
  task automatic access(input logic [TW-1:0] t, input bit eh, input bit el,
                        input bit ev, input logic [TW-1:0] evt, input int elat,
                        input string rq);
    int n;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_tag   = t;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk(req_ready == 1'b0, "R11", "ready while busy", int'(req_ready), 0);
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk((n - 1) == elat, "R10", $sformatf("latency tag %0h", t), n - 1, elat);
    chk(hit == eh, rq, $sformatf("hit tag %0h", t), int'(hit), int'(eh));
    chk(class_lir == el, rq, $sformatf("class tag %0h", t), int'(class_lir), int'(el));
    chk(victim_valid == ev, rq, $sformatf("victim_valid tag %0h", t),
        int'(victim_valid), int'(ev));
    if (ev) begin
      chk(victim_tag == evt, rq, $sformatf("victim_tag tag %0h", t),
          int'(victim_tag), int'(evt));
    end
    @(negedge clk);
    chk(done == 1'b0, "R11", "done single cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_tag   = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "ready/done in reset",
        int'({req_ready, done}), 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(hit == 1'b0 && victim_valid == 1'b0 && class_lir == 1'b0, "R1",
        "results after reset", int'({hit, victim_valid, class_lir}), 0);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "ready/done after reset",
        int'({req_ready, done}), 2);
  endtask

  task automatic t_warmup();
    access(8'h0A, 0, 1, 0, 8'h00, 3, "R2");
    access(8'h0B, 0, 1, 0, 8'h00, 3, "R2");
  endtask

  task automatic t_fill_evict();
    access(8'h0C, 0, 0, 0, 8'h00, 3, "R3");
    access(8'h0D, 0, 0, 1, 8'h0C, 3, "R4");
  endtask

  task automatic t_lir_hit_prune();
    access(8'h0A, 1, 1, 0, 8'h00, 3, "R5");
    access(8'h0B, 1, 1, 0, 8'h00, 5, "R5");
  endtask

  task automatic t_hir_outside();
    access(8'h0D, 1, 0, 0, 8'h00, 3, "R7");
  endtask

  task automatic t_hir_promote();
    access(8'h0D, 1, 1, 0, 8'h00, 4, "R6");
    // demoted block A heads the FIFO and is the next victim
    access(8'h0E, 0, 0, 1, 8'h0A, 3, "R6");
  endtask

  task automatic t_nonres_promote();
    access(8'h0F, 0, 0, 1, 8'h0E, 3, "R4");
    access(8'h0E, 0, 1, 1, 8'h0F, 4, "R8");
    // demoted block B is now the oldest resident HIR block
    access(8'h10, 0, 0, 1, 8'h0B, 3, "R8");
  endtask

  task automatic t_overflow();
    access(8'h11, 0, 0, 1, 8'h10, 3, "R9");
    // F was the deepest non-resident tag and was dropped: treated as new
    access(8'h0F, 0, 0, 1, 8'h11, 3, "R9");
    // H survived the second overflow, so it is still promoted on reuse
    access(8'h11, 0, 1, 1, 8'h0F, 4, "R9");
  endtask

  task automatic t_hold();
    logic [TW+2:0] snap;
    snap = {hit, class_lir, victim_valid, victim_tag};
    repeat (6) @(negedge clk);
    chk({hit, class_lir, victim_valid, victim_tag} == snap, "R11",
        "results held while idle",
        int'({hit, class_lir, victim_valid, victim_tag}), int'(snap));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_warmup();
    t_fill_evict();
    t_lir_hit_prune();
    t_hir_outside();
    t_hir_promote();
    t_nonres_promote();
    t_overflow();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule